// File: doc/BRIEF.md
# Programmable-Ratio Third-Order Sinc Decimator

This block turns a one-bit delta-sigma bitstream into signed multi-bit samples. It averages the bitstream with a third-order sinc low-pass response, built as three running-sum stages at the modulator rate and three difference stages at the output rate. It keeps one result for every N modulator samples, where N is the oversampling ratio. The block divides the main clock by two internally to produce a modulator-rate enable, `mod_en`. The bitstream source presents a new bit on `mod_bit` for every clock in which `mod_en` is high.

The ratio is set by a 3-bit select and a fast-mode bit, which together give nine choices from 64 to 16384. Both are captured only while the block is in standby. The output word is scaled by the selected ratio, so full scale is the same at every setting. A controller with three states sequences operation:
- `ST_STANDBY`: all filter state, counters and the enable are held clear, and the configuration is captured.
- `ST_SETTLE`: the first difference-stage results are dropped.
- `ST_RUN`: results are delivered.

The transitions are:
- *wake*: `ST_STANDBY` to `ST_SETTLE` when `standby` is low.
- *settled*: `ST_SETTLE` to `ST_RUN` on the third dropped result.
- *sleep*: from either active state back to `ST_STANDBY` when `standby` is high.

Top module: `sinc_decim`

## Requirements
- R1: Outside standby, `mod_en` is high on every second clock and never high on two consecutive clocks, so the modulator rate is half the clock rate. In standby it is low.
- R2: With `turbo`=1 the ratio N is 64. With `turbo`=0 it is 128·2^`osr_sel` (0→128 … 7→16384). Consecutive `data_rdy` pulses are exactly 2·N clocks apart.
- R3: Bit 1 counts as +1 and bit 0 as −1. A constant-1 stream yields 16'h7FFF (positive full scale, saturated) and a constant-0 stream yields 16'h8000, at every ratio.
- R4: The repeating bit pattern 1,1,1,0 yields 16'h4000 (half of positive full scale). The repeating pattern 1,0,1,0 yields 16'h0000.
- R5: After leaving standby, three results are dropped. The first `data_rdy` comes after 4·N bits have been consumed, at most two bits later.
- R6: While `standby` is high, `data_rdy` and `mod_en` are low from the next clock on. Filter state, the decimation counter and the settle counter are cleared.
- R7: Changes on `osr_sel` or `turbo` outside standby have no effect on the ratio or on the output values.
- R8: `data_rdy` is a one-clock pulse. `data_out` changes only with it and holds its value between pulses.
- R9: At the largest ratio (16384) a constant-1 stream gives 16'h7FFF with no wrap-around in the filter.
- R10: During reset, `data_out` is zero and `data_rdy` and `mod_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| standby | input | 1 | High: hold the filter cleared and capture the configuration |
| osr_sel | input | 3 | Ratio select, N = 128·2^osr_sel |
| turbo | input | 1 | Forces N = 64 when high |
| mod_bit | input | 1 | Modulator bit, consumed on clocks with mod_en high |
| mod_en | output | 1 | Modulator-rate enable (clock divided by two) |
| data_out | output | 16 | Signed two's-complement result |
| data_rdy | output | 1 | One-clock pulse marking a new result |

## Verification
The bench builds the block with its default parameters: a 3-bit select with a base ratio of 128, a fast ratio of 64, a 16-bit output and three stages. With these values the ratios 64, 128, 256, 512 and 16384 can all be run in a short time. The patterns used have period four, so every harmonic lands in a null of the sinc response and each expected word is exact. Running the largest ratio once at full scale exercises the widest headroom of the accumulators.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_RUN     = 2'd2
    } sinc_state_e;

endpackage

// File: rtl/sinc_ctrl.sv
module sinc_ctrl
    import sinc_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int BASE_LOG2  = 7,
    parameter int TURBO_LOG2 = 6,
    parameter int MAX_LOG2   = 14,
    parameter int LOG2_W     = 4,
    parameter int SETTLE_N   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic [SEL_W-1:0]  osr_sel_i,
    input  logic              turbo_i,
    input  logic              comb_vld_i,
    output logic              clr_o,
    output logic              mod_en_o,
    output logic              dec_stb_o,
    output logic              run_o,
    output logic [LOG2_W-1:0] osr_log2_o
);

    localparam int CNT_W = MAX_LOG2;
    localparam int SET_W = $clog2(SETTLE_N + 1);

    sinc_state_e        st_q, st_d;
    logic               mod_en_q;
    logic               dec_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   term;
    logic [SET_W-1:0]   settle_q;
    logic [LOG2_W-1:0]  log2_q;
    logic               clr;

    assign clr  = standby_i || (st_q == ST_STANDBY);
    assign term = CNT_W'((32'd1 << log2_q) - 32'd1);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STANDBY: begin
                if (!standby_i) st_d = ST_SETTLE;                      // wake
            end
            ST_SETTLE: begin
                if (standby_i) st_d = ST_STANDBY;                      // sleep
                else if (comb_vld_i && settle_q == SET_W'(SETTLE_N - 1))
                    st_d = ST_RUN;                                     // settled
            end
            ST_RUN: begin
                if (standby_i) st_d = ST_STANDBY;                      // sleep
            end
            default: st_d = ST_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_STANDBY;
        else        st_q <= st_d;
    end

    // per-state outputs: divider, decimation counter, settle count, config
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_en_q <= 1'b0;
            dec_q    <= 1'b0;
            cnt_q    <= '0;
            settle_q <= '0;
            log2_q   <= LOG2_W'(BASE_LOG2);
        end else begin
            if (clr) begin
                mod_en_q <= 1'b0;
                dec_q    <= 1'b0;
                cnt_q    <= '0;
                settle_q <= '0;
            end else begin
                mod_en_q <= ~mod_en_q;
                dec_q    <= mod_en_q && (cnt_q == term);
                if (mod_en_q) cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
                if (st_q == ST_SETTLE && comb_vld_i) settle_q <= settle_q + 1'b1;
            end
            if (st_q == ST_STANDBY)
                log2_q <= turbo_i ? LOG2_W'(TURBO_LOG2)
                                  : LOG2_W'(BASE_LOG2) + LOG2_W'(osr_sel_i);
        end
    end

    assign clr_o      = clr;
    assign mod_en_o   = mod_en_q;
    assign dec_stb_o  = dec_q;
    assign run_o      = (st_q == ST_RUN);
    assign osr_log2_o = log2_q;

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
    parameter int W     = 44,
    parameter int ORDER = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic                bit_i,
    output logic signed [W-1:0] sum_o
);

    logic signed [W-1:0] acc_q [ORDER];
    logic signed [W-1:0] feed  [ORDER];

    // +1 for a one, -1 for a zero
    assign feed[0] = bit_i ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign feed[g] = acc_q[g-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)     acc_q[g] <= '0;
            else if (clr_i) acc_q[g] <= '0;
            else if (en_i)  acc_q[g] <= acc_q[g] + feed[g];
        end
    end

    assign sum_o = acc_q[ORDER-1];

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
    parameter int W     = 44,
    parameter int ORDER = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                stb_i,
    input  logic signed [W-1:0] x_i,
    output logic signed [W-1:0] y_o,
    output logic                vld_o
);

    logic signed [W-1:0] dly_q [ORDER];
    logic signed [W-1:0] diff  [ORDER+1];
    logic signed [W-1:0] y_q;
    logic                vld_q;

    assign diff[0] = x_i;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        assign diff[g+1] = diff[g] - dly_q[g];
        always_ff @(posedge clk) begin
            if (!rst_n)     dly_q[g] <= '0;
            else if (clr_i) dly_q[g] <= '0;
            else if (stb_i) dly_q[g] <= diff[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q   <= '0;
            vld_q <= 1'b0;
        end else if (clr_i) begin
            y_q   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= stb_i;
            if (stb_i) y_q <= diff[ORDER];
        end
    end

    assign y_o   = y_q;
    assign vld_o = vld_q;

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
    parameter int SEL_W      = 3,
    parameter int BASE_LOG2  = 7,
    parameter int TURBO_LOG2 = 6,
    parameter int OUT_W      = 16,
    parameter int ORDER      = 3,
    parameter int SETTLE_N   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [SEL_W-1:0] osr_sel,
    input  logic             turbo,
    input  logic             mod_bit,
    output logic             mod_en,
    output logic [OUT_W-1:0] data_out,
    output logic             data_rdy
);

    localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
    localparam int ACC_W    = ORDER * MAX_LOG2 + 2;
    localparam int LOG2_W   = $clog2(MAX_LOG2 + 1);
    localparam logic signed [ACC_W-1:0] POS_LIM = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

    logic                    clr;
    logic                    dec_stb;
    logic                    run;
    logic [LOG2_W-1:0]       osr_log2;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [ACC_W-1:0] comb_y;
    logic                    comb_vld;
    logic [7:0]              shamt;
    logic signed [ACC_W-1:0] shifted;
    logic [OUT_W-1:0]        word_d;
    logic [OUT_W-1:0]        data_q;
    logic                    rdy_q;
    logic                    take;

    sinc_ctrl #(
        .SEL_W      (SEL_W),
        .BASE_LOG2  (BASE_LOG2),
        .TURBO_LOG2 (TURBO_LOG2),
        .MAX_LOG2   (MAX_LOG2),
        .LOG2_W     (LOG2_W),
        .SETTLE_N   (SETTLE_N)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby),
        .osr_sel_i  (osr_sel),
        .turbo_i    (turbo),
        .comb_vld_i (comb_vld),
        .clr_o      (clr),
        .mod_en_o   (mod_en),
        .dec_stb_o  (dec_stb),
        .run_o      (run),
        .osr_log2_o (osr_log2)
    );

    sinc_integ #(.W(ACC_W), .ORDER(ORDER)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (mod_en),
        .bit_i (mod_bit),
        .sum_o (integ_sum)
    );

    sinc_comb #(.W(ACC_W), .ORDER(ORDER)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .stb_i (dec_stb),
        .x_i   (integ_sum),
        .y_o   (comb_y),
        .vld_o (comb_vld)
    );

    // gain is N^ORDER; shift so that full scale maps onto OUT_W bits
    assign shamt   = 8'(ORDER * int'(osr_log2) - (OUT_W - 1));
    assign shifted = comb_y >>> shamt;

    always_comb begin
        if (shifted > POS_LIM)      word_d = POS_LIM[OUT_W-1:0];
        else if (shifted < NEG_LIM) word_d = NEG_LIM[OUT_W-1:0];
        else                        word_d = shifted[OUT_W-1:0];
    end

    assign take = run && comb_vld && !standby;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            rdy_q <= take;
            if (take) data_q <= word_d;
        end
    end

    assign data_out = data_q;
    assign data_rdy = rdy_q;

endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
    parameter int OUT_W  = 16,
    parameter int LOG2_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              mod_en,
    input logic              data_rdy,
    input logic [OUT_W-1:0]  data_out,
    input logic [LOG2_W-1:0] osr_log2
);

    AST_EN_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |=> !mod_en);                                   // R1

    AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!data_rdy && !mod_en));                   // R6

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy |=> !data_rdy);                               // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rdy |-> $stable(data_out));                      // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en |-> $stable(osr_log2));                         // R7

endmodule

bind sinc_decim sinc_decim_chk #(.OUT_W(OUT_W), .LOG2_W(LOG2_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .mod_en   (mod_en),
    .data_rdy (data_rdy),
    .data_out (data_out),
    .osr_log2 (osr_log2)
);

// File: tb/test_sinc_decim.sv
module test_sinc_decim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b1;
    logic [2:0]  osr_sel = 3'd0;
    logic        turbo = 1'b0;
    logic        mod_bit = 1'b0;
    logic        mod_en;
    logic [15:0] data_out;
    logic        data_rdy;

    int n_tot = 0;
    int n_bad = 0;
    longint cyc = 0;
    bit done = 1'b0;

    sinc_decim i_sinc_decim (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .osr_sel  (osr_sel),
        .turbo    (turbo),
        .mod_bit  (mod_bit),
        .mod_en   (mod_en),
        .data_out (data_out),
        .data_rdy (data_rdy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // run one configuration with a period-4 pattern (bit k = pat[k%4])
    task automatic run_case(input int sel, input bit tb, input logic [3:0] pat,
                            input int nout, input logic [15:0] expv,
                            input string req, input bit chg);
        int r = tb ? 64 : (128 << sel);
        int idx = 0;
        int got = 0;
        int held_err = 0;
        int en_err = 0;
        int steps = 0;
        int limit = (4 + nout) * 2 * r + 200;
        longint last_cyc = 0;
        logic [15:0] held = '0;
        bit prev_en = 1'b0;
        standby = 1'b1;
        osr_sel = 3'(sel);
        turbo   = tb;
        repeat (3) @(negedge clk);
        standby = 1'b0;
        while (got < nout && steps < limit) begin
            @(negedge clk);
            steps++;
            if (mod_en && prev_en) en_err++;
            prev_en = mod_en;
            if (data_rdy) begin
                if (got == 0)
                    chk(idx >= 4*r && idx <= 4*r + 2, "R5", "bits before first ready",
                        idx, 4*r + 1);
                else
                    chk(cyc - last_cyc == 2*r, "R2", "clocks between ready pulses",
                        cyc - last_cyc, 2*r);
                chk(data_out == expv, req, "data word", data_out, expv);
                last_cyc = cyc;
                held = data_out;
                got++;
                if (chg && got == 1) begin
                    osr_sel = 3'd7;
                    turbo   = 1'b1;
                end
            end else if (got > 0 && data_out !== held) begin
                held_err++;
            end
            if (mod_en) begin
                mod_bit = pat[idx % 4];
                idx++;
            end
        end
        chk(got == nout, req, "results delivered", got, nout);
        chk(held_err == 0, "R8", "word changes between pulses", held_err, 0);
        chk(en_err == 0 && idx * 2 >= steps - 2, "R1", "enable at half clock rate",
            idx * 2, steps);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(data_out == 16'h0000, "R10", "data_out in reset", data_out, 0);
        chk(!data_rdy, "R10", "data_rdy in reset", data_rdy, 0);
        chk(!mod_en, "R10", "mod_en in reset", mod_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mod_en, "R1", "mod_en low in standby", mod_en, 0);
    endtask

    task automatic t_full_scale();
        run_case(0, 1'b1, 4'b1111, 4, 16'h7FFF, "R3", 1'b0);   // N=64
        run_case(0, 1'b0, 4'b0000, 3, 16'h8000, "R3", 1'b0);   // N=128
    endtask

    task automatic t_patterns();
        run_case(1, 1'b0, 4'b0111, 3, 16'h4000, "R4", 1'b0);   // N=256
        run_case(2, 1'b0, 4'b0101, 2, 16'h0000, "R4", 1'b0);   // N=512
    endtask

    task automatic t_standby();
        int errs = 0;
        run_case(0, 1'b1, 4'b1111, 2, 16'h7FFF, "R6", 1'b0);
        standby = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (data_rdy || mod_en) errs++;
        end
        chk(errs == 0, "R6", "activity during standby", errs, 0);
        run_case(0, 1'b1, 4'b0000, 2, 16'h8000, "R6", 1'b0);
    endtask

    task automatic t_cfg_ignored();
        run_case(0, 1'b0, 4'b0111, 3, 16'h4000, "R7", 1'b1);
    endtask

    task automatic t_max_ratio();
        run_case(7, 1'b0, 4'b1111, 1, 16'h7FFF, "R9", 1'b0);  // N=16384
    endtask

    initial begin
        t_reset();
        t_full_scale();
        t_patterns();
        t_standby();
        t_cfg_ignored();
        t_max_ratio();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 195000);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

endmodule